// File: doc/BRIEF.md
# Delay-and-Multiply AFSK Demodulator

This block turns a stream of signed 12-bit audio samples into 1200-baud bit decisions. The samples come from a converter that is paced at 13,200 Hz, so each bit occupies exactly eleven samples. Each new sample is multiplied by the sample taken six strobes earlier. A first-order recursive low-pass filter smooths the product, and the sign of the smoothed value separates the 1200 Hz tone (mark) from the 2200 Hz tone (space). A bit-phase counter takes a decision once per bit. Clock recovery moves the counter by one sample per bit when a sign change of the smoothed value shows that the decision point sits off the bit centre.

A small two-state machine judges whether a carrier is present. The states are HUNT (no carrier) and LOCKED (carrier present). The machine looks at every filtered sample, not only at bit decisions. The acquire transition (HUNT to LOCKED) fires on any filtered sample whose magnitude is above the threshold input. While LOCKED, a loud sample refreshes the hold-off counter and a quiet sample advances it. The expire transition (LOCKED to HUNT) fires on the quiet sample that would push the counter past 220, which is twenty bit periods. While LOCKED, every bit decision is passed on, even when the filtered value dips close to zero. Such dips occur at tone changes and in the ripple at twice the tone frequency. Frame assembly is left to a later stage.

Top module: `afsk_demod`

## Requirements
- R1: On each sample strobe the product of the current sample and the sample from six strobes earlier is formed (taps start at zero after reset), shifted right arithmetically by 8 and saturated to 16-bit two's complement.
- R2: On each strobe the filter state y becomes sat16(y + ((p - y) >>> 3)), where p is the R1 product. A steady 1200 Hz tone drives y negative and a steady 2200 Hz tone drives it positive.
- R3: A cycle without a strobe changes nothing: the value on smp_data is ignored, and neither the carrier output nor the bit outputs are affected.
- R4: The carrier output goes high (HUNT to LOCKED) one cycle after the filter stage presents a value whose magnitude is strictly greater than the unsigned value on thresh. With thresh above any reachable magnitude the block never locks.
- R5: While LOCKED, a loud filtered value clears the hold-off count and a quiet one increments it. The quiet value that would make the count 221 returns the machine to HUNT, so after the last loud value the carrier stays high through 220 quiet values and drops on the 221st.
- R6: The phase counter advances by one per filtered value. A decision is taken when it reaches 11, and it then restarts from 0. The decision is pulsed on bit_valid for one cycle, two rising edges after the strobe edge, with bit_value = 1 for mark (y negative) and 0 for space (y zero or positive).
- R7: bit_valid pulses only when the machine was LOCKED before the deciding filtered value. Every decision taken while LOCKED is output, whatever the magnitude of y at that moment.
- R8: A sign change of y is a transition. For the first transition in a bit, a counter value below 5 after the increment gets one more step added (advance), a value above 6 gets one step removed (retard), and 5 or 6 leave it unchanged. No further nudge is applied until the next decision.
- R9: After reset, carrier and bit_valid are low, the machine is in HUNT and the phase counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Strobe: smp_data holds a new audio sample |
| smp_data | input | 12 | Audio sample, two's complement |
| thresh | input | 16 | Unsigned carrier-detect magnitude threshold |
| bit_valid | output | 1 | One-cycle pulse for each bit decision passed on |
| bit_value | output | 1 | Decided bit: 1 for mark, 0 for space |
| carrier | output | 1 | High while the detector is LOCKED |

## Verification
Long runs of pure 1200 Hz and pure 2200 Hz tones establish the sign convention and the lock behaviour. Alternating bits of eleven samples, run with a raised threshold, show that decisions continue through magnitude dips because the carrier is held per sample. Alternating bits of twelve and of ten samples separate retard from advance nudging: without recovery, the number of decisions in a fixed window would differ by one from the expected count. Silence after traffic measures the 220-sample hold-off, and an unreachable threshold shows that the detector never locks. Changing smp_data between strobes shows that unstrobed data has no effect.

// File: rtl/afsk_pkg.sv
package afsk_pkg;

    // Carrier detector states
    typedef enum logic [0:0] {
        CS_HUNT   = 1'b0,
        CS_LOCKED = 1'b1
    } carrier_state_t;

    // Nudge decision of the clock recovery
    typedef enum logic [1:0] {
        NG_NONE    = 2'd0,
        NG_ADVANCE = 2'd1,
        NG_RETARD  = 2'd2
    } nudge_t;

endpackage

// File: rtl/afsk_discrim.sv
module afsk_discrim #(
    parameter int SW     = 12,
    parameter int FW     = 16,
    parameter int DELAY  = 6,
    parameter int PSHIFT = 8,
    parameter int KSHIFT = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic [SW-1:0]        smp_data,
    output logic                 filt_valid,
    output logic signed [FW-1:0] filt
);

    localparam int PW = 2 * SW;
    localparam logic signed [PW-1:0] MAXV = signed'({{(PW-FW+1){1'b0}}, {(FW-1){1'b1}}});
    localparam logic signed [PW-1:0] MINV = signed'({{(PW-FW+1){1'b1}}, {(FW-1){1'b0}}});

    function automatic logic signed [FW-1:0] sat_fw(input logic signed [PW-1:0] v);
        if (v > MAXV)      sat_fw = MAXV[FW-1:0];
        else if (v < MINV) sat_fw = MINV[FW-1:0];
        else               sat_fw = v[FW-1:0];
    endfunction

    logic signed [SW-1:0] tap_q [DELAY];
    logic signed [PW-1:0] x_ext, d_ext, prod, prod_sh, y_ext, acc;
    logic signed [FW-1:0] prod_sat, y_next;

    // Delay-and-multiply, scaling, recursive smoothing
    always_comb begin
        x_ext    = PW'($signed(smp_data));
        d_ext    = PW'(tap_q[DELAY-1]);
        prod     = x_ext * d_ext;
        prod_sh  = prod >>> PSHIFT;
        prod_sat = sat_fw(prod_sh);
        y_ext    = PW'(filt);
        acc      = y_ext + ((PW'(prod_sat) - y_ext) >>> KSHIFT);
        y_next   = sat_fw(acc);
    end

    // Sample delay line, moves only on a strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DELAY; i++) tap_q[i] <= '0;
        end else if (smp_valid) begin
            tap_q[0] <= $signed(smp_data);
            for (int i = 1; i < DELAY; i++) tap_q[i] <= tap_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt       <= '0;
            filt_valid <= 1'b0;
        end else begin
            filt_valid <= smp_valid;
            if (smp_valid) filt <= y_next;
        end
    end

    AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(filt)); // R3

    AST_FILT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt) |-> filt_valid); // R2

endmodule

// File: rtl/afsk_carrier.sv
module afsk_carrier
    import afsk_pkg::*;
#(
    parameter int FW   = 16,
    parameter int HOLD = 220
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 filt_valid,
    input  logic signed [FW-1:0] filt,
    input  logic [FW-1:0]        thresh,
    output logic                 carrier
);

    localparam int CW = $clog2(HOLD + 1);

    carrier_state_t state_q, state_d;
    logic [CW-1:0]  quiet_q, quiet_d;
    logic signed [FW:0] fx;
    logic [FW:0]    mag;
    logic           loud;

    always_comb begin
        fx   = (FW+1)'(filt);
        mag  = fx[FW] ? $unsigned(-fx) : $unsigned(fx);
        loud = mag > {1'b0, thresh};
    end

    // Next-state and hold-off logic
    always_comb begin
        state_d = state_q;
        quiet_d = quiet_q;
        if (filt_valid) begin
            unique case (state_q)
                CS_HUNT: begin
                    if (loud) begin
                        state_d = CS_LOCKED;      // acquire
                        quiet_d = '0;
                    end
                end
                CS_LOCKED: begin
                    if (loud) begin
                        quiet_d = '0;             // refresh
                    end else if (quiet_q == CW'(HOLD)) begin
                        state_d = CS_HUNT;        // expire
                        quiet_d = '0;
                    end else begin
                        quiet_d = quiet_q + 1'b1; // count
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_HUNT;
            quiet_q <= '0;
        end else begin
            state_q <= state_d;
            quiet_q <= quiet_d;
        end
    end

    // Outputs
    always_comb begin
        carrier = (state_q == CS_LOCKED);
    end

    AST_QUIET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_q <= CW'(HOLD)); // R5

    AST_LOUD_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_valid && loud) |=> carrier); // R4

    AST_EXPIRE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(carrier) |-> ($past(quiet_q) == CW'(HOLD))); // R5

    AST_HUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier |-> (quiet_q == '0)); // R5

endmodule

// File: rtl/afsk_clkrec.sv
module afsk_clkrec
    import afsk_pkg::*;
#(
    parameter int FW  = 16,
    parameter int SPB = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 filt_valid,
    input  logic signed [FW-1:0] filt,
    input  logic                 carrier,
    output logic                 bit_valid,
    output logic                 bit_value
);

    localparam int PHW  = $clog2(SPB + 1);
    localparam int HALF = SPB / 2;

    logic [PHW-1:0] phase_q, step, phase_adj;
    logic           nudged_q, prev_neg_q;
    logic           neg, edge_seen, decide;
    nudge_t         nudge;

    always_comb begin
        neg       = filt[FW-1];
        edge_seen = filt_valid && (neg != prev_neg_q);
        step      = phase_q + 1'b1;
        nudge     = NG_NONE;
        if (edge_seen && !nudged_q) begin
            if (step < PHW'(HALF))          nudge = NG_ADVANCE;
            else if (step > PHW'(HALF + 1)) nudge = NG_RETARD;
        end
        unique case (nudge)
            NG_ADVANCE: phase_adj = step + 1'b1;
            NG_RETARD:  phase_adj = step - 1'b1;
            default:    phase_adj = step;
        endcase
        decide = filt_valid && (phase_adj == PHW'(SPB));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q    <= '0;
            nudged_q   <= 1'b0;
            prev_neg_q <= 1'b0;
        end else if (filt_valid) begin
            prev_neg_q <= neg;
            if (decide) begin
                phase_q  <= '0;
                nudged_q <= 1'b0;
            end else begin
                phase_q  <= phase_adj;
                nudged_q <= nudged_q | (nudge != NG_NONE);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_valid <= 1'b0;
            bit_value <= 1'b0;
        end else begin
            bit_valid <= decide && carrier;
            if (decide) bit_value <= neg;
        end
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q < PHW'(SPB)); // R6

    AST_BIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(carrier)); // R7

    AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid); // R6

    AST_BIT_FROM_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(filt_valid)); // R6

    AST_PHASE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !filt_valid |=> $stable(phase_q)); // R8

endmodule

// File: rtl/afsk_demod.sv
module afsk_demod #(
    parameter int SAMPLE_W     = 12,
    parameter int FILT_W       = 16,
    parameter int SPB          = 11,
    parameter int DELAY_TAPS   = 6,
    parameter int PROD_SHIFT   = 8,
    parameter int IIR_SHIFT    = 3,
    parameter int SILENCE_BITS = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [FILT_W-1:0]   thresh,
    output logic                bit_valid,
    output logic                bit_value,
    output logic                carrier
);

    localparam int HOLD = SPB * SILENCE_BITS;

    logic                     filt_valid;
    logic signed [FILT_W-1:0] filt;

    afsk_discrim #(
        .SW     (SAMPLE_W),
        .FW     (FILT_W),
        .DELAY  (DELAY_TAPS),
        .PSHIFT (PROD_SHIFT),
        .KSHIFT (IIR_SHIFT)
    ) u_discrim (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .filt_valid (filt_valid),
        .filt       (filt)
    );

    afsk_carrier #(
        .FW   (FILT_W),
        .HOLD (HOLD)
    ) u_carrier (
        .clk        (clk),
        .rst_n      (rst_n),
        .filt_valid (filt_valid),
        .filt       (filt),
        .thresh     (thresh),
        .carrier    (carrier)
    );

    afsk_clkrec #(
        .FW  (FILT_W),
        .SPB (SPB)
    ) u_clkrec (
        .clk        (clk),
        .rst_n      (rst_n),
        .filt_valid (filt_valid),
        .filt       (filt),
        .carrier    (carrier),
        .bit_valid  (bit_valid),
        .bit_value  (bit_value)
    );

endmodule

// File: tb/tb_afsk_demod.sv
module tb_afsk_demod;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic signed [11:0] smp_data = '0;
    logic [15:0]       thresh = 16'd1000;
    logic              bit_valid, bit_value, carrier;

    afsk_demod dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .thresh    (thresh),
        .bit_valid (bit_valid),
        .bit_value (bit_value),
        .carrier   (carrier)
    );

    always #4 clk = ~clk;

    int  tests = 0, fails = 0, nbits = 0;
    logic [31:0] hist = '0;
    real ph = 0.0;
    int  lcg = 12345;
    bit  done = 0;

    task automatic chk(string tag, bit ok, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat16(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Behavioural reference model
    int m_dl [6];
    int m_y = 0, m_cnt = 0, m_phase = 0;
    bit m_fv = 0, m_lock = 0, m_nud = 0, m_pneg = 0;
    bit e_bv = 0, e_bval = 0;

    always @(posedge clk) begin
        int mag, np, p;
        bit loud, neg, dec;
        if (!rst_n) begin
            foreach (m_dl[i]) m_dl[i] = 0;
            m_y = 0; m_cnt = 0; m_phase = 0;
            m_fv = 0; m_lock = 0; m_nud = 0; m_pneg = 0;
            e_bv = 0; e_bval = 0;
        end else begin
            e_bv = 0;
            if (m_fv) begin
                mag  = (m_y < 0) ? -m_y : m_y;
                loud = mag > int'(thresh);
                neg  = m_y < 0;
                np   = m_phase + 1;
                if (neg != m_pneg && !m_nud) begin
                    if (np < 5)      begin np = np + 1; m_nud = 1; end
                    else if (np > 6) begin np = np - 1; m_nud = 1; end
                end
                dec = (np == 11);
                e_bv = dec && m_lock;
                if (dec) begin e_bval = neg; m_phase = 0; m_nud = 0; end
                else m_phase = np;
                m_pneg = neg;
                if (!m_lock) begin
                    if (loud) begin m_lock = 1; m_cnt = 0; end
                end else if (loud) m_cnt = 0;
                else if (m_cnt == 220) begin m_lock = 0; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end
            m_fv = smp_valid;
            if (smp_valid) begin
                p = int'(smp_data) * m_dl[5];
                p = sat16(p >>> 8);
                m_y = sat16(m_y + ((p - m_y) >>> 3));
                for (int i = 5; i > 0; i--) m_dl[i] = m_dl[i-1];
                m_dl[0] = int'(smp_data);
            end
        end
    end

    // Every-cycle comparison and bit collection
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 bit_valid vs model", bit_valid == e_bv, bit_valid, e_bv);
            chk("R4/R5 carrier vs model", carrier == m_lock, carrier, m_lock);
            if (e_bv) chk("R6 bit_value vs model", bit_value == e_bval, bit_value, e_bval);
            if (bit_valid) begin
                nbits++;
                hist = {hist[30:0], bit_value};
            end
        end
    end

    task automatic send_sample(int v);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = 12'(v);
        @(negedge clk);
        smp_valid = 1'b0;
        lcg = lcg * 1103515245 + 12345;
        smp_data = lcg[27:16];  // R3: unstrobed data must be ignored
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_tone(real f, int n);
        for (int i = 0; i < n; i++) begin
            send_sample($rtoi(1500.0 * $sin(ph)));
            ph = ph + 6.283185307 * f / 13200.0;
        end
    endtask

    task automatic send_bits(int nb, int spb, bit first);
        bit b = first;
        for (int i = 0; i < nb; i++) begin
            send_tone(b ? 1200.0 : 2200.0, spb);
            b = !b;
        end
    endtask

    initial begin
        int n0, cnt;
        repeat (5) @(negedge clk);
        chk("R9 carrier after reset", carrier == 1'b0, carrier, 0);
        chk("R9 bit_valid after reset", bit_valid == 1'b0, bit_valid, 0);
        rst_n = 1'b1;

        // R3: data wiggling without strobes
        n0 = nbits;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            smp_data = 12'(i * 97 - 1800);
        end
        chk("R3 no carrier without strobes", carrier == 1'b0, carrier, 0);
        chk("R3 no bits without strobes", nbits == n0, nbits - n0, 0);

        for (int i = 0; i < 10; i++) send_sample(0);

        // R1 R2 R4: mark tone
        n0 = nbits;
        send_tone(1200.0, 22 * 11);
        chk("R4 lock on mark tone", carrier == 1'b1, carrier, 1);
        chk("R6 bit count on mark", (nbits - n0) >= 18, nbits - n0, 20);
        chk("R2 mark decodes as 1", hist[9:0] == 10'h3FF, hist[9:0], 10'h3FF);

        // R1 R2: space tone
        send_tone(2200.0, 22 * 11);
        chk("R1 space decodes as 0", hist[9:0] == 10'h000, hist[9:0], 0);

        // R7: bits continue through dips with a raised threshold
        thresh = 16'd2500;
        n0 = nbits;
        send_bits(18, 11, 1'b1);
        cnt = nbits - n0;
        chk("R7 carrier held through dips", carrier == 1'b1, carrier, 1);
        chk("R7 all decisions passed", cnt >= 17 && cnt <= 19, cnt, 18);
        thresh = 16'd1000;

        // R8: slow bits, retard
        send_bits(12, 12, 1'b1);
        n0 = nbits;
        send_bits(12, 12, 1'b1);
        cnt = nbits - n0;
        chk("R8 retard on 12-sample bits", cnt >= 11 && cnt <= 12, cnt, 12);

        // R8: fast bits, advance
        send_bits(12, 10, 1'b1);
        n0 = nbits;
        send_bits(12, 10, 1'b1);
        cnt = nbits - n0;
        chk("R8 advance on 10-sample bits", cnt >= 12 && cnt <= 13, cnt, 12);

        // R5: hold-off after traffic
        for (int i = 0; i < 220; i++) send_sample(0);
        chk("R5 carrier held 220 quiet samples", carrier == 1'b1, carrier, 1);
        for (int i = 0; i < 40; i++) send_sample(0);
        chk("R5 carrier dropped after hold-off", carrier == 1'b0, carrier, 0);
        n0 = nbits;
        for (int i = 0; i < 44; i++) send_sample(0);
        chk("R7 no bits in HUNT", nbits == n0, nbits - n0, 0);

        // R4: unreachable threshold
        thresh = 16'd30000;
        n0 = nbits;
        send_tone(1200.0, 110);
        chk("R4 no lock above reachable level", carrier == 1'b0, carrier, 0);
        chk("R7 no bits without lock", nbits == n0, nbits - n0, 0);

        // R4: re-acquire
        thresh = 16'd1000;
        send_tone(2200.0, 55);
        chk("R4 re-acquire after HUNT", carrier == 1'b1, carrier, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule